// File: doc/BRIEF.md
# Receive Polarity Auto-Correction

This block decides whether the wires of a twisted-pair receive channel are swapped and, if they are, inverts the receive path. Its inputs are link-pulse events that have already been qualified upstream. Single normal link pulses (NLP) arrive as one-cycle events, each marked with the polarity it was seen with. Fast link pulse (FLP) bursts arrive as a run of one-cycle pulse events, each also marked with a polarity, followed by a one-cycle end-of-burst strobe.

The automatic decision needs a different amount of evidence for each kind of pulse. A run of eight consecutive inverted NLPs declares a reversed pair. A single FLP burst is enough when at least four of its pulses are inverted. Once inversion is declared, it stays in force until the link is lost or the block is reset.

Management software controls the automatic path through a disable bit. While automatic correction is disabled, software can write the polarity status bit directly, and writing 1 forces inversion. While automatic correction is enabled, those writes have no effect. The recovered receive bit stream and the polarity of each incoming NLP are both passed through an XOR with the invert control.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset, `rx_invert` and `pol_status` are 0 and `rx_data_out` equals `rx_data_in`.
- R2: When automatic mode is enabled (`apol_disable`=0), `mode_active`=1 and `link_lost`=0, the eighth consecutive NLP event with `nlp_inv`=1 sets `rx_invert` on the next clock edge. Seven such events leave it at 0.
- R3: An NLP event with `nlp_inv`=0 that arrives before the eighth inverted one restarts the count, so eight new inverted NLPs are needed after it.
- R4: An FLP burst sets `rx_invert` on the clock edge at `flp_end` when the burst holds at least 4 pulses with `flp_inv`=1. A burst with 3 or fewer inverted pulses leaves `rx_invert` unchanged and does not carry its count into the next burst.
- R5: `rx_data_out` = `rx_data_in` XOR `rx_invert`, and `nlp_pol_out` = `nlp_inv` XOR `rx_invert`, with no clock delay.
- R6: In automatic mode, once `rx_invert` is 1 it stays 1 whatever pulses arrive. A cycle with `link_lost`=1 clears it on the next edge.
- R7: While `mode_active`=0 no pulse changes `rx_invert`, and any partial NLP or FLP count is discarded.
- R8: While `apol_disable`=1 no pulse changes `rx_invert`. A cycle with `wr_en`=1 loads `wr_data` into it on the next edge, so 1 forces inversion and 0 removes it.
- R9: While `apol_disable`=0, `wr_en` has no effect on `rx_invert`.
- R10: `pol_status` always equals `rx_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_active | input | 1 | 1 during auto-negotiation or 10BASE-T operation |
| link_lost | input | 1 | One-cycle link-loss indication |
| apol_disable | input | 1 | 1 disables automatic polarity correction |
| nlp_valid | input | 1 | NLP event strobe |
| nlp_inv | input | 1 | Observed polarity of the NLP (1 = inverted) |
| flp_valid | input | 1 | FLP pulse event strobe within a burst |
| flp_inv | input | 1 | Observed polarity of the FLP pulse (1 = inverted) |
| flp_end | input | 1 | End-of-burst strobe |
| wr_en | input | 1 | Software write strobe for the status bit |
| wr_data | input | 1 | Value written to the status bit |
| rx_data_in | input | 1 | Decoded receive bit before correction |
| rx_data_out | output | 1 | Receive bit after polarity correction |
| nlp_pol_out | output | 1 | NLP polarity after correction |
| rx_invert | output | 1 | Invert control |
| pol_status | output | 1 | Polarity status bit seen by management |

## Verification
The bench builds the block with its default parameters: an NLP threshold of 8, an FLP minimum of 4, and a burst size of up to 33 pulses. These values keep the whole decision space small.

For NLPs, the bench sweeps every streak length from 0 to 10. It also places a correct-polarity pulse after every possible number of inverted NLPs. For FLPs, it sweeps every count of inverted pulses from 0 to 8 within a ten-pulse burst.

The mode, disable, write and link-loss controls are then combined with an already inverted state and with a clear state. This shows that each control either takes effect or is ignored.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef struct packed {
    logic valid;
    logic inv;
  } lp_event_t;
endpackage

// File: rtl/rxpol_nlp_streak.sv
module rxpol_nlp_streak
  import rxpol_pkg::*;
#(
  parameter int unsigned NLP_THRESH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  lp_event_t ev,
  output logic      hit
);
  localparam int unsigned CW = $clog2(NLP_THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(NLP_THRESH - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (ev.valid) begin
      if (!ev.inv) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        hit   = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  nlp_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev.valid && !ev.inv) |=> (cnt_q == '0));

  // R7
  nlp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/rxpol_flp_judge.sv
module rxpol_flp_judge
  import rxpol_pkg::*;
#(
  parameter int unsigned FLP_MIN    = 4,
  parameter int unsigned MAX_PULSES = 33
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  lp_event_t ev,
  input  logic      burst_end,
  output logic      hit
);
  localparam int unsigned CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] SAT = CW'(MAX_PULSES);
  localparam logic [CW-1:0] MIN = CW'(FLP_MIN);

  logic [CW-1:0] cnt_q, cnt_d, sum;
  logic          bump;

  always_comb begin
    bump  = ev.valid && ev.inv;
    sum   = (bump && cnt_q != SAT) ? cnt_q + 1'b1 : cnt_q;
    hit   = en && burst_end && (sum >= MIN);
    cnt_d = (!en || burst_end) ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  flp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (cnt_q == '0));

  // R7
  flp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/rxpol_state.sv
module rxpol_state (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic link_lost,
  input  logic detect,
  input  logic wr_en,
  input  logic wr_data,
  output logic inv_q
);
  logic inv_d;

  always_comb begin
    inv_d = inv_q;
    if (!auto_en) begin
      if (wr_en) inv_d = wr_data;
    end else if (link_lost) begin
      inv_d = 1'b0;
    end else if (detect) begin
      inv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= 1'b0;
    else        inv_q <= inv_d;
  end

  // R6
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && inv_q && !link_lost) |=> inv_q);

  // R6
  inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && link_lost) |=> !inv_q);

  // R8
  force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && wr_en) |=> (inv_q == $past(wr_data)));

  // R9
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !detect && !link_lost) |=> $stable(inv_q));
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix
  import rxpol_pkg::*;
#(
  parameter int unsigned NLP_THRESH     = 8,
  parameter int unsigned FLP_MIN        = 4,
  parameter int unsigned FLP_MAX_PULSES = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_active,
  input  logic link_lost,
  input  logic apol_disable,
  input  logic nlp_valid,
  input  logic nlp_inv,
  input  logic flp_valid,
  input  logic flp_inv,
  input  logic flp_end,
  input  logic wr_en,
  input  logic wr_data,
  input  logic rx_data_in,
  output logic rx_data_out,
  output logic nlp_pol_out,
  output logic rx_invert,
  output logic pol_status
);
  lp_event_t nlp_ev, flp_ev;
  logic      det_en, nlp_hit, flp_hit, inv_q;

  always_comb begin
    nlp_ev = '{valid: nlp_valid, inv: nlp_inv};
    flp_ev = '{valid: flp_valid, inv: flp_inv};
    det_en = !apol_disable && mode_active && !link_lost;
  end

  rxpol_nlp_streak #(.NLP_THRESH(NLP_THRESH)) i_nlp (
    .clk(clk), .rst_n(rst_n), .en(det_en), .ev(nlp_ev), .hit(nlp_hit)
  );

  rxpol_flp_judge #(.FLP_MIN(FLP_MIN), .MAX_PULSES(FLP_MAX_PULSES)) i_flp (
    .clk(clk), .rst_n(rst_n), .en(det_en), .ev(flp_ev),
    .burst_end(flp_end), .hit(flp_hit)
  );

  rxpol_state i_state (
    .clk(clk), .rst_n(rst_n), .auto_en(!apol_disable), .link_lost(link_lost),
    .detect(nlp_hit || flp_hit), .wr_en(wr_en), .wr_data(wr_data),
    .inv_q(inv_q)
  );

  always_comb begin
    rx_invert   = inv_q;
    pol_status  = inv_q;
    rx_data_out = rx_data_in ^ inv_q;
    nlp_pol_out = nlp_inv ^ inv_q;
  end

  // R7
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_active && !apol_disable && !link_lost) |=> $stable(rx_invert));

  // R5
  data_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_out ^ rx_data_in) == rx_invert);
endmodule

// File: tb/test_rx_polarity_fix.sv
`timescale 1ns/1ps
module test_rx_polarity_fix;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_active, link_lost, apol_disable;
  logic nlp_valid, nlp_inv, flp_valid, flp_inv, flp_end;
  logic wr_en, wr_data, rx_data_in;
  logic rx_data_out, nlp_pol_out, rx_invert, pol_status;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_polarity_fix i_rx_polarity_fix (
    .clk(clk), .rst_n(rst_n), .mode_active(mode_active), .link_lost(link_lost),
    .apol_disable(apol_disable), .nlp_valid(nlp_valid), .nlp_inv(nlp_inv),
    .flp_valid(flp_valid), .flp_inv(flp_inv), .flp_end(flp_end),
    .wr_en(wr_en), .wr_data(wr_data), .rx_data_in(rx_data_in),
    .rx_data_out(rx_data_out), .nlp_pol_out(nlp_pol_out),
    .rx_invert(rx_invert), .pol_status(pol_status)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    nlp_valid = 0; nlp_inv = 0; flp_valid = 0; flp_inv = 0; flp_end = 0;
    wr_en = 0; wr_data = 0; link_lost = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); mode_active = 1; apol_disable = 0; rx_data_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic nlp(input logic inv);
    nlp_valid = 1; nlp_inv = inv;
    @(negedge clk);
    idle();
  endtask

  task automatic burst(input int ninv, input int ntot);
    for (int i = 0; i < ntot; i++) begin
      flp_valid = 1; flp_inv = (i < ninv);
      @(negedge clk);
      idle();
    end
    flp_end = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_ctl(input bit ll, input bit we, input logic wd);
    link_lost = ll; wr_en = we; wr_data = wd;
    @(negedge clk);
    idle();
  endtask

  task automatic chk_data(input string req, input logic exp_inv);
    for (int b = 0; b < 2; b++) begin
      rx_data_in = b[0];
      nlp_inv = ~b[0];
      #0.1;
      chk(req, rx_data_out, b[0] ^ exp_inv);
      chk(req, nlp_pol_out, ~b[0] ^ exp_inv);
    end
    nlp_inv = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", rx_invert, 1'b0);
    chk("R1", pol_status, 1'b0);
    chk_data("R1", 1'b0);

    // R2 streak length sweep
    for (int n = 0; n <= 10; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) nlp(1);
      chk("R2", rx_invert, (n >= 8));
      chk("R10", pol_status, (n >= 8));
    end

    // R3 correct pulse after k inverted restarts streak
    for (int k = 0; k < 8; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) nlp(1);
      nlp(0);
      for (int i = 0; i < 7; i++) nlp(1);
      chk("R3", rx_invert, 1'b0);
      nlp(1);
      chk("R3", rx_invert, 1'b1);
    end

    // R4 inverted-pulse count sweep in a 10-pulse burst
    for (int m = 0; m <= 8; m++) begin
      do_reset();
      burst(m, 10);
      chk("R4", rx_invert, (m >= 4));
    end
    // R4 no carry of counts across bursts
    do_reset();
    burst(3, 10);
    burst(3, 10);
    chk("R4", rx_invert, 1'b0);

    // R5 data path in both states
    do_reset();
    chk_data("R5", 1'b0);
    burst(5, 6);
    chk_data("R5", 1'b1);

    // R6 hold against normal pulses and bursts, clear on link loss
    for (int i = 0; i < 9; i++) nlp(0);
    burst(0, 10);
    chk("R6", rx_invert, 1'b1);
    pulse_ctl(1, 0, 0);
    chk("R6", rx_invert, 1'b0);
    chk("R10", pol_status, 1'b0);

    // R7 inactive mode blocks detection and discards counts
    do_reset();
    mode_active = 0;
    for (int i = 0; i < 10; i++) nlp(1);
    burst(8, 8);
    chk("R7", rx_invert, 1'b0);
    mode_active = 1;
    for (int i = 0; i < 5; i++) nlp(1);
    mode_active = 0; @(negedge clk); mode_active = 1;
    for (int i = 0; i < 5; i++) nlp(1);
    chk("R7", rx_invert, 1'b0);
    for (int i = 0; i < 2; i++) begin
      flp_valid = 1; flp_inv = 1; @(negedge clk); idle();
    end
    mode_active = 0; @(negedge clk); mode_active = 1;
    burst(2, 2);
    chk("R7", rx_invert, 1'b0);

    // R8 disabled: pulses ignored, writes force
    do_reset();
    apol_disable = 1;
    for (int i = 0; i < 10; i++) nlp(1);
    burst(8, 8);
    chk("R8", rx_invert, 1'b0);
    pulse_ctl(0, 1, 1);
    chk("R8", rx_invert, 1'b1);
    chk_data("R8", 1'b1);
    pulse_ctl(0, 1, 0);
    chk("R8", rx_invert, 1'b0);
    chk("R10", pol_status, 1'b0);

    // R9 enabled: writes ignored in both states
    do_reset();
    pulse_ctl(0, 1, 1);
    chk("R9", rx_invert, 1'b0);
    burst(4, 4);
    pulse_ctl(0, 1, 0);
    chk("R9", rx_invert, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule